// File: doc/BRIEF.md
# Pairwise Widening Adder

This block is one execution slice of a 128-bit vector unit. It takes one 128-bit operand and an already decoded vector sub-opcode. It reads the operand either as sixteen 8-bit lanes or as eight 16-bit lanes. Each lane is widened to twice its width, by sign extension or by zero extension. Neighbouring widened lanes are then summed in pairs, and each sum fills one lane of the wider shape. Four sub-opcode values select the shape and the kind of extension. Every other value is reported as illegal.

The input side is a single strobe with no ready signal, so the block accepts an operand on every cycle in which the strobe is high. The result is registered. It appears one clock after the strobe, together with either a valid flag or an illegal flag. There is no back-pressure. A consumer must take the result in the cycle in which it is presented, because the next strobe overwrites it. Reset is synchronous and active high.

Top module: `pwadd_top`

## Requirements
- R1: While reset is high at a rising edge, the following cycle shows out_valid = 0, out_illegal = 0 and out_vec = 0.
- R2: A strobe that carries a legal sub-opcode raises out_valid for exactly the next cycle, with out_illegal low. The legal values are 194, 195, 165 and 166.
- R3: Sub-opcode 194 treats in_vec as 8-bit lanes. Output 16-bit lane k, at bits 16k+15..16k, is the sign-extended sum of input bytes 2k and 2k+1.
- R4: Sub-opcode 195 works the same way as R3, except that the bytes are zero-extended before they are added.
- R5: Sub-opcode 165 treats in_vec as 16-bit lanes. Output 32-bit lane k, at bits 32k+31..32k, is the sign-extended sum of input halfwords 2k and 2k+1.
- R6: Sub-opcode 166 works the same way as R5, except that the halfwords are zero-extended before they are added.
- R7: Lane 0 occupies the least significant bits of both vectors. Output lane k is built only from input lanes 2k and 2k+1.
- R8: A pair sum never wraps. With signed bytes each 16-bit lane lies in -256..254. With unsigned bytes it lies in 0..510. With unsigned halfwords the upper 15 bits of each 32-bit lane are zero.
- R9: A strobe with any other sub-opcode raises out_illegal for the next cycle, keeps out_valid low and drives out_vec to zero. Every bit of the 32-bit sub-opcode counts, so 450 (194 + 256) is illegal.
- R10: out_vec is zero in every cycle in which out_valid is low.
- R11: out_valid and out_illegal are never high together.
- R12: When the strobe is low, in_vec and in_opc are ignored. The next cycle shows out_valid = 0, out_illegal = 0 and out_vec = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_stb | input | 1 | Operand strobe, one operation per high cycle |
| in_opc | input | 32 | Decoded vector sub-opcode |
| in_vec | input | 128 | Operand vector, lane 0 in the low bits |
| out_valid | output | 1 | Result valid, one cycle after a legal strobe |
| out_illegal | output | 1 | Sub-opcode not supported, one cycle after the strobe |
| out_vec | output | 128 | Pairwise widened sums, zero when not valid |

## Verification
The bound checker watches the control behaviour on every cycle. It checks that a result follows a legal strobe, that the illegal flag follows any other strobe, that an idle cycle produces nothing, that the two flags are exclusive and that the result is zero whenever valid is low. It also checks the value range of R8 for each lane of every unsigned result and every signed byte result. Only the bench's scenarios can show that each lane holds the correct sum in the correct position. These scenarios cover all four sub-opcodes, directed patterns such as all 0x80, all 0xFF, alternating extremes and a byte-index ramp, and random operands and opcodes checked against sums that the bench computes with explicit extension.

// File: rtl/pwadd_pkg.sv
`timescale 1ns/1ps
package pwadd_pkg;
  localparam int unsigned VEC_W = 128;
  localparam int unsigned OPC_W = 32;

  // sub-opcode values that select shape and extension kind
  localparam logic [OPC_W-1:0] OPC_B2H_SGN = 32'd194;
  localparam logic [OPC_W-1:0] OPC_B2H_UNS = 32'd195;
  localparam logic [OPC_W-1:0] OPC_H2W_SGN = 32'd165;
  localparam logic [OPC_W-1:0] OPC_H2W_UNS = 32'd166;

  typedef struct packed {
    logic legal;  // one of the four supported values
    logic wide;   // 1: 16-bit lanes in, 0: 8-bit lanes in
    logic sgn;    // 1: sign extension, 0: zero extension
  } pw_ctl_t;
endpackage

// File: rtl/pwadd_decode.sv
`timescale 1ns/1ps
module pwadd_decode
  import pwadd_pkg::*;
#(
  parameter int unsigned OW = OPC_W
) (
  input  logic [OW-1:0] opc,
  output pw_ctl_t       ctl
);
  always_comb begin
    ctl = '0;
    unique case (opc)
      OPC_B2H_SGN: ctl = '{legal: 1'b1, wide: 1'b0, sgn: 1'b1};
      OPC_B2H_UNS: ctl = '{legal: 1'b1, wide: 1'b0, sgn: 1'b0};
      OPC_H2W_SGN: ctl = '{legal: 1'b1, wide: 1'b1, sgn: 1'b1};
      OPC_H2W_UNS: ctl = '{legal: 1'b1, wide: 1'b1, sgn: 1'b0};
      default:     ctl = '0;
    endcase
  end
endmodule

// File: rtl/pwadd_pairsum.sv
`timescale 1ns/1ps
module pwadd_pairsum #(
  parameter int unsigned VW   = 128,
  parameter int unsigned IN_W = 8
) (
  input  logic          sgn,
  input  logic [VW-1:0] vin,
  output logic [VW-1:0] vout
);
  localparam int unsigned OUT_W  = 2 * IN_W;
  localparam int unsigned NPAIRS = VW / OUT_W;

  for (genvar k = 0; k < NPAIRS; k++) begin : g_pair
    logic [IN_W-1:0]  even_l, odd_l;
    logic [OUT_W-1:0] even_x, odd_x;
    assign even_l = vin[(2*k)*IN_W +: IN_W];
    assign odd_l  = vin[(2*k+1)*IN_W +: IN_W];
    // widen by a full lane; the sum then cannot leave the wide lane
    assign even_x = {{IN_W{sgn & even_l[IN_W-1]}}, even_l};
    assign odd_x  = {{IN_W{sgn & odd_l[IN_W-1]}}, odd_l};
    assign vout[k*OUT_W +: OUT_W] = even_x + odd_x;
  end
endmodule

// File: rtl/pwadd_outreg.sv
`timescale 1ns/1ps
module pwadd_outreg #(
  parameter int unsigned VW = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nxt_valid,
  input  logic          nxt_illegal,
  input  logic [VW-1:0] nxt_vec,
  output logic          q_valid,
  output logic          q_illegal,
  output logic [VW-1:0] q_vec
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid   <= 1'b0;
      q_illegal <= 1'b0;
      q_vec     <= '0;
    end else begin
      q_valid   <= nxt_valid;
      q_illegal <= nxt_illegal;
      q_vec     <= nxt_vec;
    end
  end
endmodule

// File: rtl/pwadd_top.sv
`timescale 1ns/1ps
module pwadd_top
  import pwadd_pkg::*;
#(
  parameter int unsigned VW  = VEC_W,
  parameter int unsigned OW  = OPC_W,
  parameter int unsigned NARROW_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_stb,
  input  logic [OW-1:0] in_opc,
  input  logic [VW-1:0] in_vec,
  output logic          out_valid,
  output logic          out_illegal,
  output logic [VW-1:0] out_vec
);
  localparam int unsigned WIDE_W = 2 * NARROW_W;

  pw_ctl_t       ctl;
  logic [VW-1:0] sum_narrow, sum_wide;
  logic          nxt_valid, nxt_illegal;
  logic [VW-1:0] nxt_vec;

  pwadd_decode #(.OW(OW)) u_dec (
    .opc (in_opc),
    .ctl (ctl)
  );

  pwadd_pairsum #(.VW(VW), .IN_W(NARROW_W)) u_sum_n (
    .sgn  (ctl.sgn),
    .vin  (in_vec),
    .vout (sum_narrow)
  );

  pwadd_pairsum #(.VW(VW), .IN_W(WIDE_W)) u_sum_w (
    .sgn  (ctl.sgn),
    .vin  (in_vec),
    .vout (sum_wide)
  );

  always_comb begin
    nxt_valid   = in_stb & ctl.legal;
    nxt_illegal = in_stb & ~ctl.legal;
    nxt_vec     = '0;
    if (nxt_valid) nxt_vec = ctl.wide ? sum_wide : sum_narrow;
  end

  pwadd_outreg #(.VW(VW)) u_oreg (
    .clk         (clk),
    .rst         (rst),
    .nxt_valid   (nxt_valid),
    .nxt_illegal (nxt_illegal),
    .nxt_vec     (nxt_vec),
    .q_valid     (out_valid),
    .q_illegal   (out_illegal),
    .q_vec       (out_vec)
  );
endmodule

// File: rtl/pwadd_checker.sv
`timescale 1ns/1ps
module pwadd_checker
  import pwadd_pkg::*;
#(
  parameter int unsigned VW = VEC_W,
  parameter int unsigned OW = OPC_W
) (
  input logic          clk,
  input logic          rst,
  input logic          in_stb,
  input logic [OW-1:0] in_opc,
  input logic [VW-1:0] in_vec,
  input logic          out_valid,
  input logic          out_illegal,
  input logic [VW-1:0] out_vec
);
  localparam int unsigned NH = VW / 16;
  localparam int unsigned NW = VW / 32;

  logic          opc_ok;
  logic [OW-1:0] last_opc;
  logic          u8_ok, s8_ok, u16_ok;
  logic [VW-1:0] vec_seen;

  assign opc_ok = (in_opc == OPC_B2H_SGN) || (in_opc == OPC_B2H_UNS) ||
                  (in_opc == OPC_H2W_SGN) || (in_opc == OPC_H2W_UNS);
  assign vec_seen = in_vec;

  always_ff @(posedge clk) begin
    if (rst) last_opc <= '0;
    else if (in_stb) last_opc <= in_opc;
  end

  always_comb begin
    u8_ok  = 1'b1;
    s8_ok  = 1'b1;
    u16_ok = 1'b1;
    for (int k = 0; k < NH; k++) begin
      if (out_vec[k*16 +: 16] > 16'd510) u8_ok = 1'b0;
      if ($signed(out_vec[k*16 +: 16]) < -16'sd256 ||
          $signed(out_vec[k*16 +: 16]) > 16'sd254) s8_ok = 1'b0;
    end
    for (int k = 0; k < NW; k++)
      if (out_vec[k*32+17 +: 15] != 15'd0) u16_ok = 1'b0;
  end

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_illegal && out_vec == '0));

  p_valid_after_legal_r2: assert property (@(posedge clk) disable iff (rst)
    (in_stb && opc_ok) |=> (out_valid && !out_illegal));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && last_opc == OPC_B2H_UNS) |-> u8_ok);

  p_signed_range_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && last_opc == OPC_B2H_SGN) |-> s8_ok);

  p_wide_unsigned_range_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && last_opc == OPC_H2W_UNS) |-> u16_ok);

  p_illegal_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (in_stb && !opc_ok) |=> (out_illegal && !out_valid && out_vec == '0));

  p_zero_when_invalid_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_vec == '0));

  p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_illegal));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (!in_stb && vec_seen != '0) |=> (!out_valid && !out_illegal));

  p_idle_any_r12: assert property (@(posedge clk) disable iff (rst)
    !in_stb |=> (!out_valid && !out_illegal && out_vec == '0));
endmodule

bind pwadd_top pwadd_checker #(.VW(VW), .OW(OW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_stb      (in_stb),
  .in_opc      (in_opc),
  .in_vec      (in_vec),
  .out_valid   (out_valid),
  .out_illegal (out_illegal),
  .out_vec     (out_vec)
);

// File: tb/pwadd_top_tb.sv
`timescale 1ns/1ps
module pwadd_top_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_stb = 1'b0;
  logic [31:0]  in_opc = '0;
  logic [127:0] in_vec = '0;
  logic         out_valid, out_illegal;
  logic [127:0] out_vec;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pwadd_top u_dut (
    .clk (clk), .rst (rst), .in_stb (in_stb), .in_opc (in_opc),
    .in_vec (in_vec), .out_valid (out_valid), .out_illegal (out_illegal),
    .out_vec (out_vec)
  );

  function automatic bit is_legal(input logic [31:0] op);
    return op == 32'd194 || op == 32'd195 || op == 32'd165 || op == 32'd166;
  endfunction

  function automatic string req_of(input logic [31:0] op);
    case (op)
      32'd194: return "R3";
      32'd195: return "R4";
      32'd165: return "R5";
      32'd166: return "R6";
      default: return "R9";
    endcase
  endfunction

  // reference: explicit extension, then per-pair sum truncated to lane width
  function automatic logic [127:0] ref_sum(input logic [31:0] op, input logic [127:0] v);
    logic [127:0] r = '0;
    logic [31:0]  s;
    int a, b;
    if (op == 32'd194 || op == 32'd195) begin
      for (int k = 0; k < 8; k++) begin
        a = (op == 32'd194) ? int'($signed(v[16*k +: 8]))   : int'(v[16*k +: 8]);
        b = (op == 32'd194) ? int'($signed(v[16*k+8 +: 8])) : int'(v[16*k+8 +: 8]);
        s = a + b;
        r[16*k +: 16] = s[15:0];
      end
    end else if (op == 32'd165 || op == 32'd166) begin
      for (int k = 0; k < 4; k++) begin
        a = (op == 32'd165) ? int'($signed(v[32*k +: 16]))    : int'(v[32*k +: 16]);
        b = (op == 32'd165) ? int'($signed(v[32*k+16 +: 16])) : int'(v[32*k+16 +: 16]);
        s = a + b;
        r[32*k +: 32] = s;
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input bit stb, input logic [31:0] op, input logic [127:0] v);
    logic [127:0] e_vec;
    bit e_val, e_ill;
    e_val = stb && is_legal(op);
    e_ill = stb && !is_legal(op);
    e_vec = e_val ? ref_sum(op, v) : '0;
    @(negedge clk);
    in_stb = stb; in_opc = op; in_vec = v;
    @(negedge clk);
    in_stb = 1'b0;
    if (!stb) begin
      chk("R12 valid", {127'd0, out_valid}, 128'd0);
      chk("R12 illegal", {127'd0, out_illegal}, 128'd0);
      chk("R12 vec", out_vec, 128'd0);
    end else begin
      chk(e_val ? "R2 valid" : "R9 valid", {127'd0, out_valid}, {127'd0, e_val});
      chk(e_ill ? "R9 illegal" : "R2 illegal", {127'd0, out_illegal}, {127'd0, e_ill});
      chk(req_of(op), out_vec, e_vec);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] ramp, alt8, alt16;
    logic [31:0]  ops [6];
    int unsigned  seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 valid", {127'd0, out_valid}, 128'd0);
    chk("R1 illegal", {127'd0, out_illegal}, 128'd0);
    chk("R1 vec", out_vec, 128'd0);

    for (int i = 0; i < 16; i++) ramp[8*i +: 8] = 8'(i);
    for (int i = 0; i < 16; i++) alt8[8*i +: 8] = i[0] ? 8'h80 : 8'h7F;
    for (int i = 0; i < 8; i++) alt16[16*i +: 16] = i[0] ? 16'h8000 : 16'h7FFF;
    ops = '{32'd194, 32'd195, 32'd165, 32'd166, 32'd0, 32'd450};

    // directed corners in both shapes, both extensions (R3..R8)
    for (int j = 0; j < 4; j++) begin
      run_op(1'b1, ops[j], {16{8'h80}});
      run_op(1'b1, ops[j], {16{8'hFF}});
      run_op(1'b1, ops[j], alt8);
      run_op(1'b1, ops[j], alt16);
      run_op(1'b1, ops[j], 128'd0);
      run_op(1'b1, ops[j], ramp);   // R7 lane order
    end
    // R7: explicit lane-position check with ramp, byte form: lane k = 4k+1
    begin
      logic [127:0] e7;
      for (int k = 0; k < 8; k++) e7[16*k +: 16] = 16'(4*k + 1);
      @(negedge clk); in_stb = 1'b1; in_opc = 32'd195; in_vec = ramp;
      @(negedge clk); in_stb = 1'b0;
      chk("R7 lane order", out_vec, e7);
    end
    // R8: extremes
    begin
      @(negedge clk); in_stb = 1'b1; in_opc = 32'd194; in_vec = {16{8'h80}};
      @(negedge clk); in_stb = 1'b0;
      chk("R8 signed min", out_vec, {8{16'hFF00}});
      @(negedge clk); in_stb = 1'b1; in_opc = 32'd195; in_vec = {16{8'hFF}};
      @(negedge clk); in_stb = 1'b0;
      chk("R8 unsigned max", out_vec, {8{16'h01FE}});
      @(negedge clk); in_stb = 1'b1; in_opc = 32'd166; in_vec = {8{16'hFFFF}};
      @(negedge clk); in_stb = 1'b0;
      chk("R8 wide unsigned max", out_vec, {4{32'h0001FFFE}});
    end
    // R9: illegal neighbours and truncation alias
    run_op(1'b1, 32'd0, {16{8'hFF}});
    run_op(1'b1, 32'd193, ramp);
    run_op(1'b1, 32'd196, ramp);
    run_op(1'b1, 32'd164, ramp);
    run_op(1'b1, 32'd167, ramp);
    run_op(1'b1, 32'd450, ramp);
    // R12: strobe low with a legal opcode and busy operand
    run_op(1'b0, 32'd194, {16{8'hFF}});
    // R10/R11 back-to-back: legal then idle
    run_op(1'b1, 32'd165, alt16);
    run_op(1'b0, 32'd165, alt16);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [127:0] v;
      logic [31:0]  op;
      bit stb;
      v = {$urandom, $urandom, $urandom, $urandom};
      op = ops[$urandom % 6];
      if (($urandom % 10) == 0) op = $urandom;
      stb = ($urandom % 8) != 0;
      run_op(stb, op, v);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule